// File: doc/BRIEF.md
# ADC Trigger-to-Command Sequencer

This block converts timer trigger events into a stream of ADC conversion commands. Every trigger input owns a programmable delay counter, so a filtered analog signal can settle before it is sampled. When a delayed trigger fires, the sequencer walks a command list starting at that trigger's pointer. It hands one command per accepted handshake to the ADC, and the burst ends at an entry flagged as last or at the final list slot. Each command names a channel, selects single or synchronous (dual) sampling, and picks a result queue. A global setting can also emit a one-cycle synchronisation pulse toward a timer.

Software fills shadow copies of the command list, the per-trigger pointers and the global setting through a simple write port. It then arms a reload. The next reload event promotes all shadow copies at once, but never while a burst is in flight. Two event mappings exist. In triggered mode each input line drives its own trigger. In sequential mode the pulses on input line 0 are handed to triggers 0, 1, 2, … in turn. The state machine has two states, ST_IDLE and ST_ISSUE. It takes the transition "burst start" from ST_IDLE to ST_ISSUE when a trigger fires with commands enabled. It takes "burst end" from ST_ISSUE back to ST_IDLE when a last-flagged or final entry is accepted. It takes "advance" within ST_ISSUE on every other accepted command.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset no command, sync pulse or overrun is output, and the active global setting is all zero, so a trigger causes no command and no sync pulse until a reload.
- R2: A trigger pulse on input k sampled at clock edge E with delay value D (register address 40+k, low 16 bits) makes cmd_valid rise after edge E+D+1.
- R3: Global setting bit 2 selects the mapping: 0 = input k drives trigger k; 1 = each pulse on input 0 goes to the next trigger in round-robin order starting at trigger 0, and inputs 1..N-1 are ignored.
- R4: A burst issues consecutive entries starting at the trigger's active pointer (address 32+k, value must be below the list depth). It advances on each cycle with cmd_valid and cmd_ready both high, and ends after accepting an entry with bit 7 set or the final list entry.
- R5: While cmd_valid is high and cmd_ready is low, cmd_valid and all command fields stay unchanged.
- R6: A list entry (addresses 0..depth-1, low 8 bits) encodes channel in bits 3:0, result queue in bits 5:4, synchronous sampling in bit 6 and last in bit 7; these appear on cmd_chan, cmd_queue, cmd_dual and cmd_last.
- R7: Global setting (address 48) bit 0 enables a one-cycle sync_out pulse in the cycle after a trigger is accepted, and bit 1 enables command issue; with bit 1 clear a fired trigger yields only the pulse.
- R8: Shadow writes to list, pointers and global setting have no effect until control (address 49) bit 0 is written and a reload_evt then arrives; a reload_evt without arming is ignored, and a reload during a burst is deferred until the burst ends.
- R9: overrun becomes set and stays set if a trigger fires during a burst, if several triggers fire in one cycle (the lowest index is served), or if a trigger pulse arrives while that trigger's delay is still counting; the affected event is dropped. Writing control bit 1 clears it.
- R10: A pointer write whose value is not below the list depth is ignored, keeping the previous shadow pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_TRIG | Trigger event pulses from timers |
| reload_evt | input | 1 | Master reload event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 16 | Register write data |
| cmd_ready | input | 1 | ADC accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_chan | output | 4 | ADC channel of the command |
| cmd_queue | output | 2 | Result queue index |
| cmd_dual | output | 1 | Synchronous sampling requested |
| cmd_last | output | 1 | Command carries the last flag |
| sync_out | output | 1 | Timer synchronisation pulse |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
The bench goes after cases where two things meet in the same cycle. One is a trigger firing on the very cycle a burst's last command is accepted; a design that checks the next state instead of the current one would accept it rather than flag overrun. Another is two delayed triggers landing together; a wrong priority would serve the higher index. A reload armed mid-burst must wait. An eager promotion would change the fields of a command that is being held back by cmd_ready, and the bench compares those fields every cycle. Sequential-mode rotation, end-of-list termination and ignored out-of-range pointers are also checked against a behavioural model. A design that got them wrong would start bursts at the wrong channel.

// File: rtl/ats_pkg.sv
package ats_pkg;

    localparam int ATS_ADDR_W   = 6;
    localparam int ATS_DATA_W   = 16;
    localparam int ATS_ADR_PTR  = 32;   // pointer k at 32+k (NUM_TRIG <= 8)
    localparam int ATS_ADR_DLY  = 40;   // delay k at 40+k
    localparam int ATS_ADR_GCFG = 48;
    localparam int ATS_ADR_CTRL = 49;   // bit0 arm reload, bit1 clear overrun

    typedef struct packed {
        logic       last;
        logic       dual;
        logic [1:0] queue;
        logic [3:0] chan;
    } cmd_t;

    typedef struct packed {
        logic seq_mode;
        logic cmd_en;
        logic sync_en;
    } gcfg_t;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } seq_st_t;

endpackage

// File: rtl/ats_regs.sv
module ats_regs
    import ats_pkg::*;
#(
    parameter int NT    = 4,
    parameter int DEPTH = 24,
    parameter int PTR_W = 5,
    parameter int DLY_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ATS_ADDR_W-1:0]           wr_addr,
    input  logic [ATS_DATA_W-1:0]           wr_data,
    input  logic                            promote,
    output cmd_t  [DEPTH-1:0]               act_list,
    output logic  [NT-1:0][PTR_W-1:0]       act_ptr,
    output logic  [NT-1:0][PTR_W-1:0]       shd_ptr,
    output gcfg_t                           act_cfg,
    output gcfg_t                           shd_cfg,
    output logic  [NT-1:0][DLY_W-1:0]       dly,
    output logic                            armed,
    output logic                            ovr_clr
);

    localparam logic [ATS_ADDR_W-1:0] A_LIST_END = ATS_ADDR_W'(DEPTH);
    localparam logic [ATS_ADDR_W-1:0] A_PTR      = ATS_ADDR_W'(ATS_ADR_PTR);
    localparam logic [ATS_ADDR_W-1:0] A_DLY      = ATS_ADDR_W'(ATS_ADR_DLY);
    localparam logic [ATS_ADDR_W-1:0] A_GCFG     = ATS_ADDR_W'(ATS_ADR_GCFG);
    localparam logic [ATS_ADDR_W-1:0] A_CTRL     = ATS_ADDR_W'(ATS_ADR_CTRL);
    localparam logic [ATS_DATA_W-1:0] D_DEPTH    = ATS_DATA_W'(DEPTH);

    cmd_t [DEPTH-1:0] shd_list;
    logic             ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign ovr_clr = ctrl_wr && wr_data[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_list <= '0;
            act_list <= '0;
            shd_ptr  <= '0;
            act_ptr  <= '0;
            shd_cfg  <= '0;
            act_cfg  <= '0;
            dly      <= '0;
        end else begin
            if (promote) begin
                act_list <= shd_list;
                act_ptr  <= shd_ptr;
                act_cfg  <= shd_cfg;
            end
            if (wr_en) begin
                if (wr_addr < A_LIST_END)
                    shd_list[wr_addr[PTR_W-1:0]] <= cmd_t'(wr_data[7:0]);
                if (wr_addr == A_GCFG)
                    shd_cfg <= gcfg_t'(wr_data[2:0]);
                for (int k = 0; k < NT; k++) begin
                    if (wr_addr == A_PTR + ATS_ADDR_W'(k) && wr_data < D_DEPTH)
                        shd_ptr[k] <= wr_data[PTR_W-1:0];
                    if (wr_addr == A_DLY + ATS_ADDR_W'(k))
                        dly[k] <= wr_data[DLY_W-1:0];
                end
            end
        end
    end

    // arming wins over the clear that a promotion performs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   armed <= 1'b0;
        else if (ctrl_wr && wr_data[0]) armed <= 1'b1;
        else if (promote)             armed <= 1'b0;
    end

endmodule

// File: rtl/ats_delay.sv
module ats_delay #(
    parameter int NT    = 4,
    parameter int DLY_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NT-1:0]             trig_in,
    input  logic                      seq_mode,
    input  logic [NT-1:0][DLY_W-1:0]  dly,
    output logic [NT-1:0]             fire,
    output logic                      drop
);

    localparam int IDX_W = (NT > 1) ? $clog2(NT) : 1;
    localparam logic [IDX_W-1:0] LAST_T = IDX_W'(NT - 1);

    logic [IDX_W-1:0] seq_idx;
    logic [NT-1:0]    ev;
    logic [NT-1:0]    lost;

    always_comb begin
        for (int k = 0; k < NT; k++)
            ev[k] = seq_mode ? (trig_in[0] && seq_idx == IDX_W'(k)) : trig_in[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_idx <= '0;
        else if (seq_mode && trig_in[0])
            seq_idx <= (seq_idx == LAST_T) ? '0 : seq_idx + IDX_W'(1);
    end

    for (genvar g = 0; g < NT; g++) begin : g_lane
        logic [DLY_W-1:0] cnt;
        logic             busy;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - DLY_W'(1);
            end else if (ev[g]) begin
                busy <= 1'b1;
                cnt  <= dly[g];
            end
        end

        assign fire[g] = busy && (cnt == '0);
        assign lost[g] = busy && ev[g];
    end

    assign drop = |lost;

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import ats_pkg::*;
#(
    parameter int NUM_TRIG   = 4,
    parameter int LIST_DEPTH = 24,
    parameter int DLY_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_TRIG-1:0]   trig_in,
    input  logic                  reload_evt,
    input  logic                  wr_en,
    input  logic [ATS_ADDR_W-1:0] wr_addr,
    input  logic [ATS_DATA_W-1:0] wr_data,
    input  logic                  cmd_ready,
    output logic                  cmd_valid,
    output logic [3:0]            cmd_chan,
    output logic [1:0]            cmd_queue,
    output logic                  cmd_dual,
    output logic                  cmd_last,
    output logic                  sync_out,
    output logic                  overrun
);

    localparam int PTR_W = $clog2(LIST_DEPTH);
    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
    localparam logic [PTR_W-1:0]    LAST_IDX = PTR_W'(LIST_DEPTH - 1);
    localparam logic [NUM_TRIG-1:0] ONE_T    = NUM_TRIG'(1);

    cmd_t  [LIST_DEPTH-1:0]           act_list;
    logic  [NUM_TRIG-1:0][PTR_W-1:0]  act_ptr, shd_ptr;
    gcfg_t                            act_cfg, shd_cfg, eff_cfg;
    logic  [NUM_TRIG-1:0][DLY_W-1:0]  dly;
    logic                             armed, ovr_clr, promote, drop;
    logic  [NUM_TRIG-1:0]             fire;
    logic                             any_fire, extra_fire;
    logic  [IDX_W-1:0]                sel;
    logic  [PTR_W-1:0]                eff_ptr, ptr_q, ptr_d;
    seq_st_t                          state, state_d;
    cmd_t                             entry;
    logic                             reload_pend, sync_q, ovr_q, ovr_set;

    ats_regs #(.NT(NUM_TRIG), .DEPTH(LIST_DEPTH), .PTR_W(PTR_W), .DLY_W(DLY_W)) u_regs (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .promote,
        .act_list, .act_ptr, .shd_ptr, .act_cfg, .shd_cfg, .dly, .armed, .ovr_clr
    );

    ats_delay #(.NT(NUM_TRIG), .DLY_W(DLY_W)) u_delay (
        .clk, .rst_n, .trig_in, .seq_mode(act_cfg.seq_mode), .dly, .fire, .drop
    );

    // lowest fired index is served
    always_comb begin
        sel = '0;
        for (int k = NUM_TRIG - 1; k >= 0; k--)
            if (fire[k]) sel = IDX_W'(k);
    end

    assign any_fire   = |fire;
    assign extra_fire = (fire & (fire - ONE_T)) != '0;
    assign promote    = (reload_pend || (reload_evt && armed)) && (state == ST_IDLE);
    assign eff_cfg    = promote ? shd_cfg : act_cfg;
    assign eff_ptr    = promote ? shd_ptr[sel] : act_ptr[sel];
    assign entry      = act_list[ptr_q];
    assign ovr_set    = drop || ((state == ST_ISSUE) ? any_fire : extra_fire);

    // next-state logic
    always_comb begin
        state_d = state;
        ptr_d   = ptr_q;
        unique case (state)
            ST_IDLE: begin
                if (any_fire && eff_cfg.cmd_en) begin       // burst start
                    state_d = ST_ISSUE;
                    ptr_d   = eff_ptr;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (entry.last || ptr_q == LAST_IDX)
                        state_d = ST_IDLE;                  // burst end
                    else
                        ptr_d = ptr_q + PTR_W'(1);          // advance
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            state <= state_d;
            ptr_q <= ptr_d;
        end
    end

    // registered outputs and reload bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_pend <= 1'b0;
            sync_q      <= 1'b0;
            ovr_q       <= 1'b0;
        end else begin
            if (promote)                  reload_pend <= 1'b0;
            else if (reload_evt && armed) reload_pend <= 1'b1;
            sync_q <= (state == ST_IDLE) && any_fire && eff_cfg.sync_en;
            if (ovr_set)      ovr_q <= 1'b1;
            else if (ovr_clr) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        cmd_valid = (state == ST_ISSUE);
        cmd_chan  = entry.chan;
        cmd_queue = entry.queue;
        cmd_dual  = entry.dual;
        cmd_last  = entry.last;
        sync_out  = sync_q;
        overrun   = ovr_q;
    end

endmodule

// File: rtl/ats_checker.sv
module ats_checker
    import ats_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic                  cmd_ready,
    input logic [3:0]            cmd_chan,
    input logic [1:0]            cmd_queue,
    input logic                  cmd_dual,
    input logic                  cmd_last,
    input logic                  overrun,
    input logic                  wr_en,
    input logic [ATS_ADDR_W-1:0] wr_addr,
    input logic [ATS_DATA_W-1:0] wr_data
);

    logic clr_req;
    assign clr_req = wr_en && (wr_addr == ATS_ADDR_W'(ATS_ADR_CTRL)) && wr_data[1];

    a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid);

    a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> $stable({cmd_chan, cmd_queue, cmd_dual, cmd_last}));

    a_r4_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_last |=> !cmd_valid);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clr_req |=> overrun);

endmodule

bind adc_trig_seq ats_checker u_ats_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_queue(cmd_queue), .cmd_dual(cmd_dual),
    .cmd_last(cmd_last), .overrun(overrun), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_adc_trig_seq.sv
module tb_adc_trig_seq;

    localparam int NT    = 4;
    localparam int DEPTH = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] trig_in = '0;
    logic          reload_evt = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          cmd_ready = 1'b0;
    logic          cmd_valid, cmd_dual, cmd_last, sync_out, overrun;
    logic [3:0]    cmd_chan;
    logic [1:0]    cmd_queue;

    adc_trig_seq #(.NUM_TRIG(NT), .LIST_DEPTH(DEPTH), .DLY_W(16)) dut (
        .clk, .rst_n, .trig_in, .reload_evt, .wr_en, .wr_addr, .wr_data,
        .cmd_ready, .cmd_valid, .cmd_chan, .cmd_queue, .cmd_dual, .cmd_last,
        .sync_out, .overrun
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, n_cmd = 0, n_sync = 0, rise_cyc = 0;
    int firsts[$];
    bit chk_on = 0, prev_v = 0, rnd_ready = 0;
    logic [7:0] lfsr = 8'h5b;

    // ---------------- behavioural reference ----------------
    logic [7:0] m_shl [DEPTH];
    logic [7:0] m_act [DEPTH];
    int   m_shp [NT], m_acp [NT], m_dly [NT], m_cnt [NT];
    bit   m_on [NT], fv [NT], ev [NT];
    logic [2:0] m_shc, m_acc, ec;
    bit   m_arm, m_pend, m_sync, m_ovr, drop, prom, ovs;
    int   m_state, m_ptr, m_seq, nf, sel, ep;
    logic [7:0] ent;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin m_shl[i] = 0; m_act[i] = 0; end
            for (int k = 0; k < NT; k++) begin
                m_shp[k] = 0; m_acp[k] = 0; m_dly[k] = 0; m_cnt[k] = 0; m_on[k] = 0;
            end
            m_shc = 0; m_acc = 0; m_arm = 0; m_pend = 0; m_sync = 0; m_ovr = 0;
            m_state = 0; m_ptr = 0; m_seq = 0;
        end else begin
            for (int k = 0; k < NT; k++) fv[k] = m_on[k] && m_cnt[k] == 0;
            for (int k = 0; k < NT; k++)
                ev[k] = m_acc[2] ? (trig_in[0] && m_seq == k) : trig_in[k];
            drop = 0;
            for (int k = 0; k < NT; k++) if (ev[k] && m_on[k]) drop = 1;
            for (int k = 0; k < NT; k++) begin
                if (m_on[k]) begin
                    if (m_cnt[k] == 0) m_on[k] = 0; else m_cnt[k]--;
                end else if (ev[k]) begin
                    m_on[k] = 1; m_cnt[k] = m_dly[k];
                end
            end
            if (m_acc[2] && trig_in[0]) m_seq = (m_seq + 1) % NT;
            prom = (m_pend || (reload_evt && m_arm)) && m_state == 0;
            ec = prom ? m_shc : m_acc;
            nf = 0; sel = -1;
            for (int k = NT - 1; k >= 0; k--) if (fv[k]) begin nf++; sel = k; end
            ep = (sel >= 0) ? (prom ? m_shp[sel] : m_acp[sel]) : 0;
            ovs = drop || (m_state == 1 ? nf > 0 : nf > 1);
            m_sync = (m_state == 0) && nf > 0 && ec[0];
            if (m_state == 0) begin
                if (nf > 0 && ec[1]) begin m_state = 1; m_ptr = ep; end
            end else if (cmd_ready) begin
                ent = m_act[m_ptr];
                if (ent[7] || m_ptr == DEPTH - 1) m_state = 0; else m_ptr++;
            end
            if (prom) begin
                for (int i = 0; i < DEPTH; i++) m_act[i] = m_shl[i];
                for (int k = 0; k < NT; k++) m_acp[k] = m_shp[k];
                m_acc = m_shc;
            end
            m_pend = prom ? 0 : (m_pend || (reload_evt && m_arm));
            if (wr_en && wr_addr == 49 && wr_data[0]) m_arm = 1;
            else if (prom) m_arm = 0;
            if (wr_en) begin
                if (wr_addr < DEPTH) m_shl[wr_addr] = wr_data[7:0];
                for (int k = 0; k < NT; k++) begin
                    if (wr_addr == 32 + k && wr_data < DEPTH) m_shp[k] = wr_data;
                    if (wr_addr == 40 + k) m_dly[k] = wr_data;
                end
                if (wr_addr == 48) m_shc = wr_data[2:0];
            end
            if (ovs) m_ovr = 1;
            else if (wr_en && wr_addr == 49 && wr_data[1]) m_ovr = 0;
        end
    end

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            cmp("R2 R4 cmd_valid", cmd_valid, m_state == 1);
            if (m_state == 1) begin
                cmp("R6 cmd_chan",  cmd_chan,  m_act[m_ptr][3:0]);
                cmp("R6 cmd_queue", cmd_queue, m_act[m_ptr][5:4]);
                cmp("R6 cmd_dual",  cmd_dual,  m_act[m_ptr][6]);
                cmp("R6 cmd_last",  cmd_last,  m_act[m_ptr][7]);
            end
            cmp("R7 sync_out", sync_out, m_sync);
            cmp("R9 overrun",  overrun,  m_ovr);
            if (cmd_valid && cmd_ready) n_cmd++;
            if (sync_out) n_sync++;
            if (cmd_valid && !prev_v) begin firsts.push_back(cmd_chan); rise_cyc = cyc; end
            prev_v = cmd_valid;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #2;
        if (rnd_ready) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = lfsr[0];
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 6'(a); wr_data = 16'(d);
        step();
        wr_en = 0;
    endtask

    task automatic pulse(logic [NT-1:0] v);
        trig_in = v; step(); trig_in = '0;
    endtask

    task automatic reload();
        reload_evt = 1; step(); reload_evt = 0;
    endtask

    int t0, c0, s0, nf0;

    initial begin
        idle(3);
        rst_n = 1;
        chk_on = 1;
        idle(1);
        cmp("R1 reset cmd_valid", cmd_valid, 0);
        cmp("R1 reset sync_out", sync_out, 0);
        cmp("R1 reset overrun", overrun, 0);

        pulse(4'b0001);
        idle(6);
        cmp("R1 no command before reload", n_cmd + n_sync, 0);

        // list: chan=i%16, queue=(i/2)%4, dual when i%3==0, last at 2,5,6,12
        for (int i = 0; i < DEPTH; i++)
            wr(i, (i % 16) | (((i / 2) % 4) << 4) | ((i % 3 == 0) << 6)
                  | ((i == 2 || i == 5 || i == 6 || i == 12) << 7));
        wr(32, 0); wr(33, 3); wr(34, 6); wr(35, 20);
        wr(40, 0); wr(41, 3); wr(42, 1); wr(43, 5);
        wr(48, 3); wr(49, 1);
        reload();
        idle(2);

        cmd_ready = 1;
        c0 = n_cmd; t0 = cyc;
        pulse(4'b0001);
        idle(8);
        cmp("R4 burst length from trigger 0", n_cmd - c0, 3);
        cmp("R2 zero delay latency", rise_cyc - t0, 2);

        rnd_ready = 1;
        t0 = cyc;
        pulse(4'b0010);
        idle(18);
        cmp("R2 delay 3 latency", rise_cyc - t0, 5);
        c0 = n_cmd;
        pulse(4'b1000);
        idle(25);
        cmp("R4 burst stops at final entry", n_cmd - c0, 4);
        pulse(4'b0100);
        idle(10);

        // overrun: fire during a stalled burst
        rnd_ready = 0; cmd_ready = 0;
        pulse(4'b0001);
        idle(3);
        pulse(4'b0100);
        idle(4);
        cmd_ready = 1;
        idle(8);
        cmp("R9 overrun after fire in burst", overrun, 1);
        wr(49, 2);
        idle(1);
        cmp("R9 overrun cleared", overrun, 0);

        // simultaneous fire: trigger 2 (delay 1) then trigger 0 (delay 0)
        pulse(4'b0100);
        pulse(4'b0001);
        idle(10);
        cmp("R9 lowest index served", firsts[$], 0);
        cmp("R9 overrun on simultaneous fire", overrun, 1);
        wr(49, 2);

        // second pulse while delay still counting
        rnd_ready = 1;
        pulse(4'b1000);
        idle(1);
        pulse(4'b1000);
        idle(25);
        cmp("R9 overrun on pulse during delay", overrun, 1);
        wr(49, 2);
        rnd_ready = 0; cmd_ready = 1;

        // unarmed reload ignored
        wr(32, 9);
        reload();
        idle(2);
        pulse(4'b0001);
        idle(8);
        cmp("R8 unarmed reload ignored", firsts[$], 0);

        // armed reload during a burst is deferred
        cmd_ready = 0;
        pulse(4'b0001);
        idle(3);
        wr(49, 1);
        reload();
        idle(3);
        cmd_ready = 1;
        idle(8);
        pulse(4'b0001);
        idle(10);
        cmp("R8 deferred reload applied", firsts[$], 9);

        // out-of-range pointer ignored
        wr(32, 30);
        wr(49, 1);
        reload();
        idle(2);
        pulse(4'b0001);
        idle(10);
        cmp("R10 out-of-range pointer ignored", firsts[$], 9);

        // sync only
        wr(48, 1); wr(49, 1);
        reload();
        idle(2);
        c0 = n_cmd; s0 = n_sync;
        pulse(4'b0010);
        idle(10);
        cmp("R7 sync only: no command", n_cmd - c0, 0);
        cmp("R7 sync only: one pulse", n_sync - s0, 1);

        // sequential mode
        wr(48, 7); wr(49, 1);
        reload();
        idle(2);
        nf0 = firsts.size();
        pulse(4'b0010);
        idle(10);
        for (int i = 0; i < 5; i++) begin
            pulse(4'b0001);
            idle(20);
        end
        cmp("R3 sequential burst count", firsts.size() - nf0, 5);
        if (firsts.size() - nf0 == 5) begin
            cmp("R3 seq step 0", firsts[nf0],     9);
            cmp("R3 seq step 1", firsts[nf0 + 1], 3);
            cmp("R3 seq step 2", firsts[nf0 + 2], 6);
            cmp("R3 seq step 3", firsts[nf0 + 3], 4);
            cmp("R3 seq wrap",   firsts[nf0 + 4], 9);
        end

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule